// File: doc/BRIEF.md
# Vectored Interrupt Controller with Acknowledge Handshake

This block gathers sixteen hardware request lines and presents them to a processor through one interrupt output. The lines fall into two groups of eight. A rising edge on any line is captured as a pending request. When an unmasked pending request outranks everything currently being serviced, the interrupt output is raised. The processor answers with a one-cycle acknowledge. On the cycle after the acknowledge, the controller places the 8-bit vector number of the chosen request on the vector bus, together with a one-cycle valid flag. The processor then uses that number as an index into its table of handler addresses.

The lower group (lines 0 to 7) is assigned to one vector window and the upper group (lines 8 to 15) to a separate, non-contiguous window. Priority is fixed, with line 0 highest. A per-line mask register can hold off a line without losing its request. An in-service register stops requests of equal or lower priority from interrupting a handler until an end-of-interrupt strobe retires it. A request of higher priority can still nest.

Top module: `vector_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, the valid flag is low, and the pending, in-service and mask registers are all clear.
- R2: A pending bit is set only by a low-to-high transition of its line. A line that stays high does not request again once its request has been delivered.
- R3: The interrupt output is high exactly when some pending, unmasked line has a lower index than every line that is in service. When nothing is in service, any pending, unmasked line raises it.
- R4: A set mask bit keeps its line out of the interrupt output and out of selection, but the request stays pending. Clearing the mask bit later lets the request through.
- R5: At acknowledge the eligible line with the lowest index is chosen.
- R6: The vector for line n is 0x08+n for n in 0..7 and 0x70+(n-8) for n in 8..15.
- R7: The valid flag is high in the cycle after each clock edge that samples the acknowledge high, and low in every other cycle. The vector bus is meaningful while the flag is high.
- R8: An acknowledge with no eligible request returns vector 0x0F and changes no pending or in-service state.
- R9: Delivering a vector clears that line's pending bit and sets its in-service bit. From then on, equal and lower priority requests are held off.
- R10: An end-of-interrupt strobe clears only the highest-priority (lowest index) in-service bit.
- R11: A higher-priority request raises the interrupt output and can be delivered while a lower-priority line is in service.
- R12: A new rising edge on a line in the same cycle that the line's vector is delivered leaves that line pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| irqIn | input | 16 | Request lines, index 0 highest priority |
| maskWe | input | 1 | Loads maskIn into the mask register |
| maskIn | input | 16 | New mask value, a set bit masks its line |
| ackIn | input | 1 | Acknowledge from the processor |
| eoiIn | input | 1 | End-of-interrupt strobe |
| intOut | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector number of the delivered request |
| vecValid | output | 1 | Vector bus valid, one cycle per acknowledge |

## Verification
Three pairs of events can fall on the same clock edge: an acknowledge and an end-of-interrupt, an acknowledge and a fresh rising edge on the line being delivered, and an acknowledge and a mask write. In each pair, selection uses the state from before the edge, and both updates then apply together. Directed sequences place a re-raised line exactly on the acknowledge cycle and an end-of-interrupt next to an acknowledge. Random traffic with frequent acknowledges and strobes produces many more such coincidences. A bench reference model, built from the requirements, predicts the vector, the valid flag and the interrupt output on every cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic ackTake;   // acknowledge seen this cycle
    logic deliver;   // an eligible line wins the acknowledge
    logic eoiClear;  // retire the top in-service line
    logic maskLoad;  // load a new mask value
  } vicStrobe_t;

endpackage

// File: rtl/vic_prio_pick.sv
// Fixed-priority picker: the lowest set index wins.
module vic_prio_pick #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] req,
  output logic [WIDTH-1:0] grantOh,
  output logic             anySet
);

  logic [WIDTH-1:0] carry;

  // ripple "something below already won" chain
  assign carry[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < WIDTH; g++) begin : g_chain
      assign carry[g] = carry[g-1] | req[g-1];
    end
  endgenerate

  assign grantOh = req & ~carry;
  assign anySet  = |req;

endmodule

// File: rtl/vic_ctrl.sv
// Priority resolution and strobe generation.
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_LINES = 16,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ackIn,
  input  logic                 eoiIn,
  input  logic                 maskWe,
  input  logic [NUM_LINES-1:0] pendQ,
  input  logic [NUM_LINES-1:0] isrQ,
  input  logic [NUM_LINES-1:0] maskQ,
  output vicStrobe_t           strb,
  output logic [NUM_LINES-1:0] pickOh,
  output logic [IDX_W-1:0]     pickIdx,
  output logic [NUM_LINES-1:0] eoiOh,
  output logic                 intOut
);

  logic [NUM_LINES-1:0] isrTopOh;
  logic                 isrAny;
  logic [NUM_LINES-1:0] allowed;
  logic [NUM_LINES-1:0] cand;
  logic                 candAny;

  vic_prio_pick #(.WIDTH(NUM_LINES)) isrPick_i (
    .req(isrQ), .grantOh(isrTopOh), .anySet(isrAny)
  );

  // only lines strictly above the top in-service line may interrupt
  assign allowed = isrAny ? (isrTopOh - NUM_LINES'(1)) : '1;
  assign cand    = pendQ & ~maskQ & allowed;

  vic_prio_pick #(.WIDTH(NUM_LINES)) candPick_i (
    .req(cand), .grantOh(pickOh), .anySet(candAny)
  );

  always_comb begin
    pickIdx = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (pickOh[i]) pickIdx = IDX_W'(i);
  end

  assign intOut        = candAny;
  assign eoiOh         = isrTopOh;
  assign strb.ackTake  = ackIn;
  assign strb.deliver  = ackIn & candAny;
  assign strb.eoiClear = eoiIn & isrAny;
  assign strb.maskLoad = maskWe;

  // R5: at most one line selected
  a_r5_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pickOh));
  // R3: interrupt output needs an unmasked pending line
  a_r3_int_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    intOut |-> ((pendQ & ~maskQ) != '0));
  // R10: end-of-interrupt retires one line at most
  a_r10_eoi_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoiOh));

endmodule

// File: rtl/vic_datapath.sv
// State registers and vector formation.
module vic_datapath
  import vic_pkg::*;
#(
  parameter int       NUM_LINES = 16,
  parameter int       GROUP_SIZE = 8,
  parameter int       VEC_W     = 8,
  parameter logic [7:0] BASE_LO  = 8'h08,
  parameter logic [7:0] BASE_HI  = 8'h70,
  parameter logic [7:0] IDLE_VEC = 8'h0F,
  localparam int      IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic [NUM_LINES-1:0] maskIn,
  input  vicStrobe_t           strb,
  input  logic [NUM_LINES-1:0] pickOh,
  input  logic [IDX_W-1:0]     pickIdx,
  input  logic [NUM_LINES-1:0] eoiOh,
  output logic [NUM_LINES-1:0] pendQ,
  output logic [NUM_LINES-1:0] isrQ,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);

  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] riseEdge;
  logic [NUM_LINES-1:0] delivMask;
  logic [NUM_LINES-1:0] retireMask;
  logic [VEC_W-1:0]     mappedVec;

  assign riseEdge   = irqIn & ~prevQ;
  assign delivMask  = strb.deliver ? pickOh : '0;
  assign retireMask = strb.eoiClear ? eoiOh : '0;

  // two groups mapped to separate windows
  always_comb begin
    if (int'(pickIdx) < GROUP_SIZE)
      mappedVec = VEC_W'(BASE_LO) + VEC_W'(pickIdx);
    else
      mappedVec = VEC_W'(BASE_HI) + VEC_W'(int'(pickIdx) - GROUP_SIZE);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevQ    <= '0;
      pendQ    <= '0;
      isrQ     <= '0;
      maskQ    <= '0;
      vecOut   <= VEC_W'(IDLE_VEC);
      vecValid <= 1'b0;
    end else begin
      prevQ    <= irqIn;
      pendQ    <= (pendQ & ~delivMask) | riseEdge;
      isrQ     <= (isrQ & ~retireMask) | delivMask;
      if (strb.maskLoad) maskQ <= maskIn;
      vecValid <= strb.ackTake;
      if (strb.ackTake)
        vecOut <= strb.deliver ? mappedVec : VEC_W'(IDLE_VEC);
    end
  end

  // R9: delivered line enters service
  a_r9_deliver_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    strb.deliver |=> ((isrQ & $past(pickOh)) != '0));
  // R8: empty acknowledge yields the idle vector
  a_r8_idle_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.ackTake && !strb.deliver) |=> (vecOut == VEC_W'(IDLE_VEC)));
  // R2: a pending bit appears only after a rising edge
  a_r2_pend_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendQ & ~$past(pendQ)) & ~($past(irqIn) & ~$past(prevQ))) == '0);

endmodule

// File: rtl/vector_irq_ctrl.sv
module vector_irq_ctrl
  import vic_pkg::*;
#(
  parameter int         GROUP_SIZE = 8,
  parameter int         VEC_W      = 8,
  parameter logic [7:0] BASE_LO    = 8'h08,
  parameter logic [7:0] BASE_HI    = 8'h70,
  parameter logic [7:0] IDLE_VEC   = 8'h0F,
  localparam int        NUM_LINES  = 2 * GROUP_SIZE,
  localparam int        IDX_W      = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqIn,
  input  logic                 maskWe,
  input  logic [NUM_LINES-1:0] maskIn,
  input  logic                 ackIn,
  input  logic                 eoiIn,
  output logic                 intOut,
  output logic [VEC_W-1:0]     vecOut,
  output logic                 vecValid
);

  vicStrobe_t           strb;
  logic [NUM_LINES-1:0] pendQ, isrQ, maskQ, pickOh, eoiOh;
  logic [IDX_W-1:0]     pickIdx;

  vic_ctrl #(.NUM_LINES(NUM_LINES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .ackIn(ackIn), .eoiIn(eoiIn), .maskWe(maskWe),
    .pendQ(pendQ), .isrQ(isrQ), .maskQ(maskQ), .strb(strb),
    .pickOh(pickOh), .pickIdx(pickIdx), .eoiOh(eoiOh), .intOut(intOut)
  );

  vic_datapath #(
    .NUM_LINES(NUM_LINES), .GROUP_SIZE(GROUP_SIZE), .VEC_W(VEC_W),
    .BASE_LO(BASE_LO), .BASE_HI(BASE_HI), .IDLE_VEC(IDLE_VEC)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .maskIn(maskIn), .strb(strb),
    .pickOh(pickOh), .pickIdx(pickIdx), .eoiOh(eoiOh),
    .pendQ(pendQ), .isrQ(isrQ), .maskQ(maskQ),
    .vecOut(vecOut), .vecValid(vecValid)
  );

  // R7: valid flag tracks the acknowledge one cycle later
  a_r7_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ackIn |=> vecValid);
  a_r7_valid_only_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !ackIn |=> !vecValid);

endmodule

// File: tb/vector_irq_ctrl_tb_top.sv
module vector_irq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irqIn = '0;
  logic        maskWe = 1'b0;
  logic [15:0] maskIn = '0;
  logic        ackIn = 1'b0;
  logic        eoiIn = 1'b0;
  logic        intOut;
  logic [7:0]  vecOut;
  logic        vecValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [15:0] pendM = '0, isrM = '0, maskM = '0, prevM = '0;

  vector_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irqIn(irqIn), .maskWe(maskWe), .maskIn(maskIn),
    .ackIn(ackIn), .eoiIn(eoiIn), .intOut(intOut), .vecOut(vecOut),
    .vecValid(vecValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] lowestBit(input logic [15:0] v);
    for (int i = 0; i < 16; i++) if (v[i]) return 16'(1) << i;
    return '0;
  endfunction

  function automatic logic [15:0] allowedBy(input logic [15:0] isr);
    logic [15:0] top = lowestBit(isr);
    return (isr == '0) ? 16'hFFFF : (top - 16'd1);
  endfunction

  function automatic logic [7:0] vecFor(input logic [15:0] oh);
    for (int i = 0; i < 16; i++)
      if (oh[i]) return (i < 8) ? 8'(8'h08 + i) : 8'(8'h70 + i - 8);
    return 8'h0F;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, advance the model, check after the edge
  task automatic cycle(input logic [15:0] irq, input bit ack, input bit eoi,
                       input bit mwe, input logic [15:0] mval, input string tag);
    logic [15:0] cand, win, eoiClr;
    logic [7:0]  expVec;
    irqIn = irq; ackIn = ack; eoiIn = eoi; maskWe = mwe; maskIn = mval;
    cand   = pendM & ~maskM & allowedBy(isrM);
    win    = ack ? lowestBit(cand) : '0;
    expVec = vecFor(win);
    eoiClr = eoi ? lowestBit(isrM) : '0;
    pendM  = (pendM & ~win) | (irq & ~prevM);
    isrM   = (isrM & ~eoiClr) | win;
    if (mwe) maskM = mval;
    prevM  = irq;
    @(posedge clk);
    @(negedge clk);
    check(tag, "vecValid", 8'(vecValid), 8'(ack));
    if (ack) check(tag, "vecOut", vecOut, expVec);
    check(tag, "intOut", 8'(intOut),
          8'(((pendM & ~maskM & allowedBy(isrM)) != '0)));
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] irqR;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", "intOut", 8'(intOut), 8'd0);
    check("R1", "vecValid", 8'(vecValid), 8'd0);
    cycle('0, 1, 0, 0, '0, "R1");          // empty ack just after reset

    // line 3 rises, acknowledge, hold high
    cycle(16'h0008, 0, 0, 0, '0, "R3");
    cycle(16'h0008, 1, 0, 0, '0, "R6");    // expect 0x0B
    cycle(16'h0008, 0, 0, 0, '0, "R7");    // valid drops
    cycle(16'h0008, 0, 0, 0, '0, "R2");    // steady level: no new request
    cycle(16'h0028, 0, 0, 0, '0, "R9");    // line 5 blocked by line 3
    cycle(16'h002A, 0, 0, 0, '0, "R11");   // line 1 nests
    cycle(16'h002A, 1, 0, 0, '0, "R11");   // expect 0x09
    cycle(16'h002A, 0, 1, 0, '0, "R10");   // retires line 1 only
    cycle(16'h002A, 0, 1, 0, '0, "R10");   // retires line 3, line 5 shows
    cycle(16'h002A, 1, 0, 0, '0, "R5");    // expect 0x0D
    cycle('0, 0, 1, 0, '0, "R10");

    // mask line 12
    cycle('0, 0, 0, 1, 16'h1000, "R4");
    cycle(16'h1000, 0, 0, 0, '0, "R4");
    cycle(16'h1000, 1, 0, 0, '0, "R8");    // masked: idle vector
    cycle(16'h1000, 0, 0, 1, 16'h0000, "R4");
    cycle(16'h1000, 1, 0, 0, '0, "R6");    // expect 0x74
    cycle('0, 0, 1, 0, '0, "R10");

    // simultaneous lines 2 and 9
    cycle(16'h0204, 0, 0, 0, '0, "R5");
    cycle(16'h0204, 1, 0, 0, '0, "R5");    // expect 0x0A
    cycle(16'h0204, 0, 1, 0, '0, "R10");
    cycle(16'h0204, 1, 0, 0, '0, "R6");    // expect 0x71
    cycle('0, 0, 1, 0, '0, "R10");

    // R12: re-raise line 6 on the delivery cycle
    cycle(16'h0040, 0, 0, 0, '0, "R12");
    cycle(16'h0000, 0, 0, 0, '0, "R12");
    cycle(16'h0040, 1, 0, 0, '0, "R12");   // new edge on ack cycle
    cycle(16'h0040, 0, 1, 0, '0, "R12");   // after retire the line shows again
    cycle(16'h0040, 1, 1, 0, '0, "R12");   // ack and retire together
    cycle('0, 0, 1, 0, '0, "R12");

    // random traffic
    irqR = '0;
    for (int n = 0; n < 3000; n++) begin
      for (int b = 0; b < 16; b++)
        if (($urandom % 16) == 0) irqR[b] = ~irqR[b];
      cycle(irqR, ($urandom % 4) == 0, ($urandom % 5) == 0,
            ($urandom % 25) == 0, 16'($urandom), "R3");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule